// File: doc/BRIEF.md
# Gamma Lookup and Overlay Colour Mixer

This block is a per-pixel colour stage for 24-bit RGB video. Each incoming pixel is first mapped through three independent 256-entry, 8-bit tables, one per colour channel, which are typically loaded with gamma or contrast curves. Each table can be bypassed on its own. The mapped pixel is then combined with one of three programmable overlay colours. A 2-bit overlay key selects the colour, and this key comes either from external pins or from an on-screen-display source. Each key value has its own combining operation: replace, AND, OR or XOR. Outside the visible picture, a border flag substitutes a programmable border colour.

Software configures the block through a simple byte-wide register write port. The write port sets the table write channel and index, and table data written through the same port is stored at that index. The port also programs the per-key operations, the overlay and border colours, and a test field that forces the key. The pixel path has a fixed latency of two clocks, and the valid strobe is delayed to match.

Pixels are packed with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Register addresses are 5 bits wide:

| Address | Contents |
|---|---|
| 0 | Table control: bits 1:0 select the written table (00 red, 01 green, 10 blue, 11 none); bit 2 enables the red table; bit 3 enables the green table; bit 4 enables the blue table |
| 1 | Table index |
| 2 | Table data |
| 3 | Overlay control: bits 1:0 are the key-01 operation, bits 3:2 the key-10 operation, bits 5:4 the key-11 operation; bit 7 is the key-11 table route |
| 4 to 6 | Colour 1: R, G, B |
| 7 to 9 | Colour 2: R, G, B |
| 10 to 12 | Colour 3: R, G, B |
| 13 to 15 | Border colour: R, G, B |
| 16 | Key force: bits 1:0 |

Top module: `ovl_lut_mixer`

## Requirements
- R1: After reset, out_rgb is 0 and out_valid is 0. The table enables, the operations, the route bit, the force field and the border colour reset to 0. Colour 1 resets to 0000FF (blue), colour 2 to FFFF00 (yellow) and colour 3 to FF0000 (red).
- R2: Every pixel appears on out_rgb exactly two clocks after it is presented. out_valid equals in_valid delayed by two clocks.
- R3: A write to address 2 stores the data byte in the table chosen by address 0 bits 1:0 (00 red, 01 green, 10 blue), at the index held in address 1. With select 11, the write changes no table.
- R4: When the enable bit of a channel is 1 (address 0 bit 2 for red, bit 3 for green, bit 4 for blue), that channel's output value is its table entry at the input value. When the bit is 0, the input value passes unchanged.
- R5: With effective key 00 and no border, the output is the table-stage pixel.
- R6: Effective keys 01, 10 and 11 select colours 1, 2 and 3, with operations in address 3 bits 1:0, 3:2 and 5:4 respectively. Operation code 00 outputs the colour, 01 outputs the table-stage pixel AND the colour, 10 outputs the pixel OR the colour, and 11 outputs the pixel XOR the colour.
- R7: When address 3 bit 7 is 1 and the effective key is 11, the output is the table-stage pixel and the key-11 operation code is ignored.
- R8: When address 16 bits 1:0 are nonzero, they replace in_key as the effective key.
- R9: When in_border is 1, the output is the border colour, whatever the key.
- R10: A pixel that reads a table entry in the same cycle that entry is written gets the old value. The next read gets the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_rgb | input | 24 | Input pixel, R in bits 23:16, G in bits 15:8, B in bits 7:0 |
| in_key | input | 2 | Overlay key from pins or the on-screen-display source |
| in_border | input | 1 | Pixel lies outside the visible picture |
| in_valid | input | 1 | Input pixel strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| out_rgb | output | 24 | Mixed output pixel |
| out_valid | output | 1 | Output pixel strobe, two clocks after in_valid |

## Verification
The bench targets the collision where a table entry is written and read in the same cycle. A design that forwards the new data would show the new value one pixel too early. It also checks that table select 11 writes nothing; a decoder that wraps would corrupt a table. Key 11 is driven both with and without the route bit, so a design that lets operation code 3 win would output a combined colour where the plain mapped pixel is due. Random configurations mix forced keys, border pixels and gaps in the valid strobe. These catch a priority error between border, force and key, and a valid strobe that is off by one stage.

// File: rtl/ovl_mix_pkg.sv
`timescale 1ns/1ps
// Shared widths, types and register addresses of the colour mixer.
package ovl_mix_pkg;
    localparam int CH_W       = 8;             // bits per colour channel
    localparam int NCH        = 3;             // channels per pixel (R, G, B)
    localparam int NKEY       = 3;             // overlay colours, keys 1..3
    localparam int PIX_W      = CH_W * NCH;
    localparam int REG_ADDR_W = 5;

    // Register addresses
    localparam int A_LUTCTL   = 0;
    localparam int A_LUTIDX   = 1;
    localparam int A_LUTDAT   = 2;
    localparam int A_OVLCTL   = 3;
    localparam int A_COL_BASE = 4;             // 3 colours then border, R/G/B each
    localparam int A_FORCE    = A_COL_BASE + (NKEY + 1) * NCH;

    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        OP_REPL = 2'b00,
        OP_AND  = 2'b01,
        OP_OR   = 2'b10,
        OP_XOR  = 2'b11
    } ovl_op_e;
endpackage

// File: rtl/ovl_cfg_regs.sv
`timescale 1ns/1ps
// Configuration register file of the mixer.
// Holds table control, overlay control, colours, border colour and key force.
// Assumes a single-cycle write strobe; no read-back path is provided.
module ovl_cfg_regs
    import ovl_mix_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]       wr_data,
    output logic [1:0]            lut_wsel,
    output logic [NCH-1:0]        lut_en,
    output logic [CH_W-1:0]       lut_idx,
    output logic                  lut_we,
    output logic [CH_W-1:0]       lut_wdata,
    output logic [NKEY-1:0][1:0]  ovl_op,
    output logic                  lut_route,
    output pix_t [NKEY-1:0]       ovl_col,
    output pix_t                  brd_col,
    output logic [1:0]            force_key
);
    localparam int NBYTE = (NKEY + 1) * NCH;

    logic [4:0]      lutctl_q;
    logic [CH_W-1:0] lutidx_q;
    logic [5:0]      ops_q;
    logic            route_q;
    logic [1:0]      force_q;

    // Reset value of colour byte j: colour 1 blue, colour 2 yellow, colour 3 red, border black.
    function automatic logic [CH_W-1:0] byte_rst(input int j);
        int col;
        int ch;
        col = j / NCH;
        ch  = j % NCH;
        if ((col == 0 && ch == 2) || (col == 1 && ch < 2) || (col == 2 && ch == 0))
            return '1;
        return '0;
    endfunction

    // Control registers written by address decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lutctl_q <= '0;
            lutidx_q <= '0;
            ops_q    <= '0;
            route_q  <= 1'b0;
            force_q  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_ADDR_W'(A_LUTCTL): lutctl_q <= wr_data[4:0];
                REG_ADDR_W'(A_LUTIDX): lutidx_q <= wr_data;
                REG_ADDR_W'(A_OVLCTL): begin
                    ops_q   <= wr_data[5:0];
                    route_q <= wr_data[7];
                end
                REG_ADDR_W'(A_FORCE):  force_q <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    for (genvar j = 0; j < NBYTE; j++) begin : g_byte
        logic [CH_W-1:0] q;
        // One colour byte with its own reset value.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= byte_rst(j);
            else if (wr_en && wr_addr == REG_ADDR_W'(A_COL_BASE + j))
                q <= wr_data;
        end
    end

    for (genvar k = 0; k < NKEY; k++) begin : g_col
        assign ovl_col[k] = {g_byte[k*NCH].q, g_byte[k*NCH+1].q, g_byte[k*NCH+2].q};
        assign ovl_op[k]  = ops_q[2*k +: 2];
    end
    assign brd_col = {g_byte[NKEY*NCH].q, g_byte[NKEY*NCH+1].q, g_byte[NKEY*NCH+2].q};

    assign lut_wsel  = lutctl_q[1:0];
    assign lut_en    = lutctl_q[4:2];
    assign lut_idx   = lutidx_q;
    assign lut_we    = wr_en && (wr_addr == REG_ADDR_W'(A_LUTDAT));
    assign lut_wdata = wr_data;
    assign lut_route = route_q;
    assign force_key = force_q;

    AST_FORCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> force_key == $past(force_key)); // R8
endmodule

// File: rtl/gamma_lut_stage.sv
`timescale 1ns/1ps
// First pipeline stage: per-channel lookup tables with individual bypass.
// Each table is a synchronous-read RAM; a same-cycle write and read of one
// entry returns the stored (old) value. Key, border and valid ride along.
module gamma_lut_stage
    import ovl_mix_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pix_t            pix_in,
    input  logic [1:0]      key_in,
    input  logic            border_in,
    input  logic            valid_in,
    input  logic [NCH-1:0]  lut_en,
    input  logic [1:0]      lut_wsel,
    input  logic            lut_we,
    input  logic [CH_W-1:0] lut_idx,
    input  logic [CH_W-1:0] lut_wdata,
    output pix_t            pix_out,
    output logic [1:0]      key_out,
    output logic            border_out,
    output logic            valid_out
);
    localparam int DEPTH = 1 << CH_W;

    // Side-band registers travelling with the pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_out    <= '0;
            border_out <= 1'b0;
            valid_out  <= 1'b0;
        end else begin
            key_out    <= key_in;
            border_out <= border_in;
            valid_out  <= valid_in;
        end
    end

    // Channel c = 0 is red (top byte), 1 green, 2 blue.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int LSB = (NCH - 1 - c) * CH_W;
        logic [CH_W-1:0] mem [DEPTH];
        logic [CH_W-1:0] rd_q;
        logic [CH_W-1:0] raw_q;
        logic            en_q;

        // Table write port and registered read of the incoming channel value.
        always_ff @(posedge clk) begin
            if (lut_we && lut_wsel == 2'(c))
                mem[lut_idx] <= lut_wdata;
            rd_q <= mem[pix_in[LSB +: CH_W]];
        end

        // Raw value and enable captured for the bypass path.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q <= '0;
                en_q  <= 1'b0;
            end else begin
                raw_q <= pix_in[LSB +: CH_W];
                en_q  <= lut_en[c];
            end
        end

        assign pix_out[LSB +: CH_W] = en_q ? rd_q : raw_q;

        AST_LUT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
            !lut_en[c] |=> pix_out[LSB +: CH_W] == $past(pix_in[LSB +: CH_W])); // R4
        AST_LUT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (lut_we && lut_wsel == 2'(c)) |=> mem[$past(lut_idx)] == $past(lut_wdata)); // R3
    end

    AST_VALID_S1_HI: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R2
    AST_VALID_S1_LO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out); // R2
endmodule

// File: rtl/overlay_combine.sv
`timescale 1ns/1ps
// Second pipeline stage: border substitution and keyed overlay combine.
// Priority: border, then key-11 table route, then key 00 pass, then the
// per-key operation with the selected colour. Assumes config is stable.
module overlay_combine
    import ovl_mix_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  pix_t                 vid,
    input  logic [1:0]           key,
    input  logic                 border,
    input  logic                 valid,
    input  logic [NKEY-1:0][1:0] ovl_op,
    input  logic                 lut_route,
    input  pix_t [NKEY-1:0]      ovl_col,
    input  pix_t                 brd_col,
    output pix_t                 out_pix,
    output logic                 out_valid
);
    ovl_op_e sel_op;
    pix_t    sel_col;
    pix_t    mixed;
    logic    passthru;

    // Pick operation and colour belonging to the key.
    always_comb begin
        sel_op  = OP_REPL;
        sel_col = '0;
        case (key)
            2'b01: begin sel_op = ovl_op_e'(ovl_op[0]); sel_col = ovl_col[0]; end
            2'b10: begin sel_op = ovl_op_e'(ovl_op[1]); sel_col = ovl_col[1]; end
            2'b11: begin sel_op = ovl_op_e'(ovl_op[2]); sel_col = ovl_col[2]; end
            default: ;
        endcase
    end

    // Apply the selected logic operation.
    always_comb begin
        case (sel_op)
            OP_AND:  mixed = vid & sel_col;
            OP_OR:   mixed = vid | sel_col;
            OP_XOR:  mixed = vid ^ sel_col;
            default: mixed = sel_col;
        endcase
    end

    assign passthru = (key == 2'b00) || (key == 2'b11 && lut_route);

    // Output register with border priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pix   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= valid;
            if (border)
                out_pix <= brd_col;
            else if (passthru)
                out_pix <= vid;
            else
                out_pix <= mixed;
        end
    end

    AST_BORDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        border |=> out_pix == $past(brd_col)); // R9
    AST_NO_KEY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!border && key == 2'b00) |=> out_pix == $past(vid)); // R5
    AST_ROUTE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!border && key == 2'b11 && lut_route) |=> out_pix == $past(vid)); // R7
    AST_REPLACE_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (!border && !passthru && sel_op == OP_REPL) |=> out_pix == $past(sel_col)); // R6
    AST_VALID_S2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> out_valid); // R2
endmodule

// File: rtl/ovl_lut_mixer.sv
`timescale 1ns/1ps
// Top of the colour mixer: register file, table stage and combine stage.
// Fixed two-clock pixel latency; the forced key is resolved at the input.
module ovl_lut_mixer
    import ovl_mix_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PIX_W-1:0]      in_rgb,
    input  logic [1:0]            in_key,
    input  logic                  in_border,
    input  logic                  in_valid,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [CH_W-1:0]       wr_data,
    output logic [PIX_W-1:0]      out_rgb,
    output logic                  out_valid
);
    logic [1:0]           lut_wsel;
    logic [NCH-1:0]       lut_en;
    logic [CH_W-1:0]      lut_idx;
    logic                 lut_we;
    logic [CH_W-1:0]      lut_wdata;
    logic [NKEY-1:0][1:0] ovl_op;
    logic                 lut_route;
    pix_t [NKEY-1:0]      ovl_col;
    pix_t                 brd_col;
    logic [1:0]           force_key;
    logic [1:0]           eff_key;
    pix_t                 s1_pix;
    logic [1:0]           s1_key;
    logic                 s1_border;
    logic                 s1_valid;

    assign eff_key = (force_key != 2'b00) ? force_key : in_key;

    ovl_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lut_wsel  (lut_wsel),
        .lut_en    (lut_en),
        .lut_idx   (lut_idx),
        .lut_we    (lut_we),
        .lut_wdata (lut_wdata),
        .ovl_op    (ovl_op),
        .lut_route (lut_route),
        .ovl_col   (ovl_col),
        .brd_col   (brd_col),
        .force_key (force_key)
    );

    gamma_lut_stage u_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_in     (in_rgb),
        .key_in     (eff_key),
        .border_in  (in_border),
        .valid_in   (in_valid),
        .lut_en     (lut_en),
        .lut_wsel   (lut_wsel),
        .lut_we     (lut_we),
        .lut_idx    (lut_idx),
        .lut_wdata  (lut_wdata),
        .pix_out    (s1_pix),
        .key_out    (s1_key),
        .border_out (s1_border),
        .valid_out  (s1_valid)
    );

    overlay_combine u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .vid       (s1_pix),
        .key       (s1_key),
        .border    (s1_border),
        .valid     (s1_valid),
        .ovl_op    (ovl_op),
        .lut_route (lut_route),
        .ovl_col   (ovl_col),
        .brd_col   (brd_col),
        .out_pix   (out_rgb),
        .out_valid (out_valid)
    );

    AST_FORCE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (force_key != 2'b00) |=> s1_key == $past(force_key)); // R8
    AST_PIN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (force_key == 2'b00) |=> s1_key == $past(in_key)); // R8
endmodule

// File: tb/sim_ovl_lut_mixer.sv
`timescale 1ns/1ps
module sim_ovl_lut_mixer;
    import ovl_mix_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [PIX_W-1:0]      in_rgb = '0;
    logic [1:0]            in_key = '0;
    logic                  in_border = 1'b0;
    logic                  in_valid = 1'b0;
    logic                  wr_en = 1'b0;
    logic [REG_ADDR_W-1:0] wr_addr = '0;
    logic [CH_W-1:0]       wr_data = '0;
    logic [PIX_W-1:0]      out_rgb;
    logic                  out_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ovl_lut_mixer u0 (
        .clk(clk), .rst_n(rst_n), .in_rgb(in_rgb), .in_key(in_key),
        .in_border(in_border), .in_valid(in_valid), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_rgb(out_rgb), .out_valid(out_valid)
    );

    // Reference model state, from the requirements
    logic [CH_W-1:0] m_lut [3][256];
    logic            m_en [3];
    logic [1:0]      m_op [3];
    pix_t            m_col [3];
    pix_t            m_brd;
    logic            m_route;
    logic [1:0]      m_force;
    logic [1:0]      m_sel;
    logic [CH_W-1:0] m_idx;

    // Two-deep expectation pipe
    logic  p1_val = 1'b0, p2_val = 1'b0;
    pix_t  p1_exp = '0,   p2_exp = '0;
    string p1_tag = "",   p2_tag = "";

    function automatic pix_t model_pix(input pix_t v, input logic [1:0] key, input logic brd);
        pix_t       lv;
        pix_t       c;
        logic [1:0] k;
        logic [1:0] op;
        for (int ch = 0; ch < 3; ch++) begin
            logic [CH_W-1:0] x;
            x = v[(2-ch)*CH_W +: CH_W];
            lv[(2-ch)*CH_W +: CH_W] = m_en[ch] ? m_lut[ch][x] : x;
        end
        k = (m_force != 2'b00) ? m_force : key;
        if (brd) return m_brd;
        if (k == 2'b00) return lv;
        if (k == 2'b11 && m_route) return lv;
        c  = m_col[k-1];
        op = m_op[k-1];
        case (op)
            2'b00:   return c;
            2'b01:   return lv & c;
            2'b10:   return lv | c;
            default: return lv ^ c;
        endcase
    endfunction

    function automatic string pick_tag(input logic [1:0] k, input logic b);
        if (b) return "R9";
        if (m_force != 2'b00) return "R8";
        if (k == 2'b00) return "R5";
        if (k == 2'b11 && m_route) return "R7";
        return "R6";
    endfunction

    function automatic logic [CH_W-1:0] lut_pat(input int s, input int i);
        case (s)
            0:       return CH_W'(i) ^ 8'h5A;
            1:       return ~CH_W'(i);
            default: return CH_W'(i * 3 + 7);
        endcase
    endfunction

    task automatic model_write(input int addr, input logic [CH_W-1:0] d);
        if (addr == A_LUTCTL) begin
            m_sel = d[1:0];
            m_en[0] = d[2]; m_en[1] = d[3]; m_en[2] = d[4];
        end else if (addr == A_LUTIDX) begin
            m_idx = d;
        end else if (addr == A_LUTDAT) begin
            if (m_sel != 2'b11) m_lut[m_sel][m_idx] = d;
        end else if (addr == A_OVLCTL) begin
            m_op[0] = d[1:0]; m_op[1] = d[3:2]; m_op[2] = d[5:4];
            m_route = d[7];
        end else if (addr >= A_COL_BASE && addr < A_COL_BASE + 12) begin
            int j, col, ch;
            j = addr - A_COL_BASE; col = j / 3; ch = j % 3;
            if (col < 3) m_col[col][(2-ch)*CH_W +: CH_W] = d;
            else         m_brd[(2-ch)*CH_W +: CH_W] = d;
        end else if (addr == A_FORCE) begin
            m_force = d[1:0];
        end
    endtask

    // One clock: check the pixel from two steps ago, then drive new inputs.
    task automatic step(input pix_t v, input logic [1:0] k, input logic b, input logic val,
                        input logic we, input int addr, input logic [CH_W-1:0] d,
                        input string tag);
        @(negedge clk);
        n_checks++;
        if (out_valid !== p2_val) begin
            n_fail++;
            $display("FAIL R2: out_valid=%b expected %b", out_valid, p2_val);
        end
        if (p2_val) begin
            n_checks++;
            if (out_rgb !== p2_exp) begin
                n_fail++;
                $display("FAIL %s: out_rgb=%h expected %h", p2_tag, out_rgb, p2_exp);
            end
        end
        p2_val = p1_val; p2_exp = p1_exp; p2_tag = p1_tag;
        p1_val = val;    p1_exp = model_pix(v, k, b); p1_tag = tag;
        in_rgb = v; in_key = k; in_border = b; in_valid = val;
        wr_en = we; wr_addr = REG_ADDR_W'(addr); wr_data = d;
        if (we) model_write(addr, d);
    endtask

    task automatic wr(input int addr, input logic [CH_W-1:0] d);
        step('0, 2'b00, 1'b0, 1'b0, 1'b1, addr, d, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 2'b00, 1'b0, 1'b0, 1'b0, 0, '0, "");
    endtask

    task automatic px(input pix_t v, input logic [1:0] k, input logic b, input string tag);
        step(v, k, b, 1'b1, 1'b0, 0, '0, tag);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < 3; c++) begin
            m_en[c] = 1'b0; m_op[c] = 2'b00;
            for (int i = 0; i < 256; i++) m_lut[c][i] = '0;
        end
        m_col[0] = 24'h0000FF; m_col[1] = 24'hFFFF00; m_col[2] = 24'hFF0000;
        m_brd = '0; m_route = 1'b0; m_force = 2'b00; m_sel = 2'b00; m_idx = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (out_rgb !== '0 || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_rgb=%h out_valid=%b expected 000000 0", out_rgb, out_valid);
        end

        // R1: reset colours with replace operation and tables bypassed
        px(24'h123456, 2'b01, 1'b0, "R1");
        px(24'h123456, 2'b10, 1'b0, "R1");
        px(24'h123456, 2'b11, 1'b0, "R1");
        px(24'h89ABCD, 2'b00, 1'b0, "R5");
        idle(2);

        // R3: fill all three tables
        for (int s = 0; s < 3; s++) begin
            wr(A_LUTCTL, CH_W'(s));
            for (int i = 0; i < 256; i++) begin
                wr(A_LUTIDX, CH_W'(i));
                wr(A_LUTDAT, lut_pat(s, i));
            end
        end
        // R3: select 11 writes nothing
        wr(A_LUTCTL, 8'h1F);
        wr(A_LUTIDX, 8'h05);
        wr(A_LUTDAT, 8'h77);
        idle(2);
        px(24'h050505, 2'b00, 1'b0, "R3");
        px(24'h00FF80, 2'b00, 1'b0, "R3");
        idle(2);

        // R4: individual channel enables
        wr(A_LUTCTL, 8'h04);
        idle(2);
        px(24'h102030, 2'b00, 1'b0, "R4");
        idle(2);
        wr(A_LUTCTL, 8'h10);
        idle(2);
        px(24'h102030, 2'b00, 1'b0, "R4");
        idle(2);

        // R10: same-cycle write and read of one entry
        wr(A_LUTCTL, 8'h04);
        wr(A_LUTIDX, 8'h40);
        idle(2);
        step(24'h400000, 2'b00, 1'b0, 1'b1, 1'b1, A_LUTDAT, 8'hAA, "R10");
        px(24'h400000, 2'b00, 1'b0, "R10");
        idle(2);

        // R7: route on, then off with XOR on key 11
        wr(A_LUTCTL, 8'h1C);
        wr(A_OVLCTL, 8'hB0);
        idle(2);
        px(24'h336699, 2'b11, 1'b0, "R7");
        idle(2);
        wr(A_OVLCTL, 8'h30);
        idle(2);
        px(24'h336699, 2'b11, 1'b0, "R6");
        idle(2);

        // R8: forced key overrides pin key 00
        wr(A_FORCE, 8'h02);
        idle(2);
        px(24'hA5A5A5, 2'b00, 1'b0, "R8");
        idle(2);
        wr(A_FORCE, 8'h00);

        // R9: border overrides key 11
        wr(A_COL_BASE + 9,  8'h11);
        wr(A_COL_BASE + 10, 8'h22);
        wr(A_COL_BASE + 11, 8'h33);
        idle(2);
        px(24'h777777, 2'b11, 1'b1, "R9");
        idle(2);

        // Random configurations and pixel streams
        for (int r = 0; r < 25; r++) begin
            idle(2);
            wr(A_LUTCTL, CH_W'($urandom_range(0, 255)));
            wr(A_OVLCTL, CH_W'($urandom_range(0, 255)));
            for (int j = 0; j < 4; j++)
                wr(A_COL_BASE + $urandom_range(0, 11), CH_W'($urandom_range(0, 255)));
            wr(A_FORCE, ($urandom_range(0, 3) == 0) ? CH_W'($urandom_range(1, 3)) : 8'h00);
            for (int n = 0; n < 40; n++) begin
                pix_t       v;
                logic [1:0] k;
                logic       b;
                logic       val;
                v   = PIX_W'($urandom());
                k   = 2'($urandom_range(0, 3));
                b   = ($urandom_range(0, 7) == 0);
                val = ($urandom_range(0, 4) != 0);
                step(v, k, b, val, 1'b0, 0, '0, pick_tag(k, b));
            end
        end
        idle(2);

        summary();
        $finish;
    end
endmodule